// File: doc/BRIEF.md
# Segmented Character-Match Unit

This unit searches one vector for characters that also appear in a second vector. Each element of the first operand is compared with every element in the matching aligned 128-bit segment of the second operand. Elements in other segments are never compared. The unit works on either 8-bit or 16-bit elements. In match mode an element's result is set when it equals at least one element of its segment. In no-match mode the result is set when the element differs from all of them.

Results are written into a predicate that has one bit per byte lane. A governing predicate gates this output, so inactive lanes always read 0. The unit also produces N, Z, C and V condition flags in the style of a predicate test. The vector length is fixed by the parameter `VL_BITS`. One 128-bit segment is processed per clock, from the highest segment down to the lowest. When the whole vector is finished, a one-cycle `done` strobe is raised. The predicate and flags then hold until the next accepted start.

Top module: `seg_char_match`

## Requirements
- R1: With `size_sel`=0 (bytes) and `nomatch`=0, predicate bit i is 1 when byte i of `vec_a` equals any byte of `vec_b` in the same aligned 16-byte segment (byte offsets i with the low 4 bits cleared). Bytes of `vec_b` in any other segment are never compared.
- R2: With `nomatch`=1, an element's result is 1 only when its value differs from every element of its segment of `vec_b`.
- R3: With `size_sel`=1 (halfwords), element j occupies bytes 2j and 2j+1 and is compared with the eight halfwords of its segment. Its result goes to predicate bit 2j. Every odd predicate bit is written as 0, and odd bits of `gov` have no effect.
- R4: Each result bit is ANDed with its `gov` bit, so a lane whose `gov` bit is 0 (an inactive lane) always reads 0.
- R5: Once `done` has been raised, the flags are set as follows. `flag_n` equals the result of the lowest-numbered active lane. `flag_z` is 1 when no predicate bit is set. `flag_c` is 1 when the result of the highest-numbered active lane is 0. `flag_v` is always 0.
- R6: When no lane is active, the predicate is all zeros and the flags are N=0, Z=1, C=1, V=0. This is also the state after reset.
- R7: A start accepted at clock edge t raises `done` for exactly one cycle after edge t+VL_BITS/128. The predicate and flags then hold until the next accepted start.
- R8: A start with `size_sel`=2 or 3 is illegal. It raises `done` and `undef` together for one cycle, one edge after the start, and leaves the predicate and flags unchanged.
- R9: A `start` that arrives while an operation is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation; operands are sampled at this edge |
| nomatch | input | 1 | 0 = match mode, 1 = no-match mode |
| size_sel | input | 2 | 0 = byte, 1 = halfword, 2/3 = illegal |
| vec_a | input | VL_BITS | Elements that are searched for |
| vec_b | input | VL_BITS | Characters to search within, taken per segment |
| gov | input | VL_BITS/8 | Governing predicate, one bit per byte lane |
| pred | output | VL_BITS/8 | Destination predicate |
| flag_n | output | 1 | Result of the first active lane |
| flag_z | output | 1 | No result bit set |
| flag_c | output | 1 | Result of the last active lane is 0 |
| flag_v | output | 1 | Always 0 |
| done | output | 1 | One-cycle completion strobe |
| undef | output | 1 | Illegal size, raised together with done |

## Verification
The bench places a character in `vec_a` whose only copy in `vec_b` sits in the other segment. A design that compared across the whole vector would report a false match there. Halfword runs use small values and set odd `gov` bits, so a design that compared bytes, or that leaked odd lanes, would set bits that must stay 0. Sparse and empty governing predicates are used to test the flags. A design that took the first or last lane from the raw predicate instead of the active lanes would get N or C wrong. Illegal sizes and a start issued while busy are also driven. A design that wrote a result for either of them would overwrite a predicate that must be held.

// File: rtl/seg_char_match.sv
module seg_char_match #(
  parameter int VL_BITS = 256
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 nomatch,
  input  logic [1:0]           size_sel,
  input  logic [VL_BITS-1:0]   vec_a,
  input  logic [VL_BITS-1:0]   vec_b,
  input  logic [VL_BITS/8-1:0] gov,
  output logic [VL_BITS/8-1:0] pred,
  output logic                 flag_n,
  output logic                 flag_z,
  output logic                 flag_c,
  output logic                 flag_v,
  output logic                 done,
  output logic                 undef
);
  localparam int PB   = VL_BITS / 8;
  localparam int NSEG = VL_BITS / 128;
  localparam int SW   = (NSEG > 1) ? $clog2(NSEG) : 1;

  logic [VL_BITS-1:0] a_r, b_r;
  logic [PB-1:0]      g_r, lo_hot, hi_hot, half_mask;
  logic               half_r, neg_r, busy;
  logic [SW-1:0]      seg;
  logic [127:0]       sa, sb;
  logic [15:0]        hit_b, hit_h, seg_res, seg_gov;

  always_comb begin
    for (int i = 0; i < PB; i++) half_mask[i] = (i % 2 == 0);
  end

  assign sa      = a_r[int'(seg)*128 +: 128];
  assign sb      = b_r[int'(seg)*128 +: 128];
  assign seg_gov = g_r[int'(seg)*16 +: 16];

  always_comb begin
    hit_b = '0;
    hit_h = '0;
    for (int j = 0; j < 16; j++)
      for (int k = 0; k < 16; k++)
        if (sa[8*j +: 8] == sb[8*k +: 8]) hit_b[j] = 1'b1;
    for (int j = 0; j < 8; j++)
      for (int k = 0; k < 8; k++)
        if (sa[16*j +: 16] == sb[16*k +: 16]) hit_h[2*j] = 1'b1;
  end

  assign seg_res = ((half_r ? hit_h : hit_b) ^ {16{neg_r}}) & seg_gov;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_r    <= '0;
      b_r    <= '0;
      g_r    <= '0;
      half_r <= 1'b0;
      neg_r  <= 1'b0;
      busy   <= 1'b0;
      seg    <= '0;
      pred   <= '0;
      done   <= 1'b0;
      undef  <= 1'b0;
    end else begin
      done  <= 1'b0;
      undef <= 1'b0;
      if (busy) begin
        pred[int'(seg)*16 +: 16] <= seg_res;
        if (seg == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          seg <= seg - 1'b1;
        end
      end else if (start) begin
        if (size_sel[1]) begin
          done  <= 1'b1;
          undef <= 1'b1;
        end else begin
          a_r    <= vec_a;
          b_r    <= vec_b;
          g_r    <= size_sel[0] ? (gov & half_mask) : gov;
          half_r <= size_sel[0];
          neg_r  <= nomatch;
          busy   <= 1'b1;
          seg    <= SW'(NSEG - 1);
          pred   <= '0;
        end
      end
    end
  end

  assign lo_hot = g_r & (~g_r + 1'b1);

  always_comb begin
    hi_hot = '0;
    for (int i = 0; i < PB; i++)
      if (g_r[i]) hi_hot = PB'(1) << i;
  end

  assign flag_n = |(pred & lo_hot);
  assign flag_z = ~|pred;
  assign flag_c = ~|(pred & hi_hot);
  assign flag_v = 1'b0;
endmodule

// File: rtl/seg_char_match_chk.sv
module seg_char_match_chk #(
  parameter int VL_BITS = 256
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start,
  input logic [1:0]           size_sel,
  input logic                 busy,
  input logic                 half_r,
  input logic [VL_BITS/8-1:0] g_r,
  input logic [VL_BITS/8-1:0] pred,
  input logic                 flag_n,
  input logic                 flag_z,
  input logic                 flag_c,
  input logic                 done,
  input logic                 undef
);
  localparam int PB = VL_BITS / 8;
  logic [PB-1:0] odd_mask;
  always_comb begin
    for (int i = 0; i < PB; i++) odd_mask[i] = (i % 2 == 1);
  end

  p_inactive_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((pred & ~g_r) == '0));
  p_half_odd_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && half_r) |-> ((pred & odd_mask) == '0));
  p_empty_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && g_r == '0) |-> (flag_z && flag_c && !flag_n));
  p_n_excl_z_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flag_n |-> !flag_z);
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_illegal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && size_sel[1]) |=> (done && undef && $stable(pred)));
  p_undef_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    undef |-> done);
  p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(g_r));
endmodule

bind seg_char_match seg_char_match_chk #(.VL_BITS(VL_BITS)) u_chk (.*);

// File: tb/test_seg_char_match.sv
module test_seg_char_match;
  localparam int VL   = 256;
  localparam int PB   = VL / 8;
  localparam int NSEG = VL / 128;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, nomatch = 1'b0;
  logic [1:0] size_sel = 2'd0;
  logic [VL-1:0] vec_a = '0, vec_b = '0;
  logic [PB-1:0] gov = '0, pred;
  logic flag_n, flag_z, flag_c, flag_v, done, undef;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  seg_char_match #(.VL_BITS(VL)) i_seg_char_match (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void model(input logic [VL-1:0] a, input logic [VL-1:0] b,
      input logic [PB-1:0] g, input logic half, input logic neg,
      output logic [PB-1:0] p, output logic n, output logic z, output logic c);
    logic [PB-1:0] ge;
    int first, last;
    p = '0; ge = '0; first = -1; last = -1;
    for (int i = 0; i < PB; i++) begin
      logic hit;
      int base;
      if (half && (i % 2 == 1)) continue;
      ge[i] = g[i];
      base = (i / 16) * 16;
      hit = 1'b0;
      for (int k = base; k < base + 16; k += (half ? 2 : 1))
        if (half ? (a[i*8 +: 16] == b[k*8 +: 16]) : (a[i*8 +: 8] == b[k*8 +: 8])) hit = 1'b1;
      p[i] = (hit ^ neg) & g[i];
    end
    for (int i = 0; i < PB; i++)
      if (ge[i]) begin
        if (first < 0) first = i;
        last = i;
      end
    n = (first >= 0) ? p[first] : 1'b0;
    c = (last >= 0) ? ~p[last] : 1'b1;
    z = (p == '0);
  endfunction

  task automatic run(input logic [1:0] sz, input logic neg, output int cyc);
    @(negedge clk);
    size_sel = sz; nomatch = neg; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic fill(input int range);
    for (int i = 0; i < PB; i++) begin
      vec_a[i*8 +: 8] = 8'($urandom % range);
      vec_b[i*8 +: 8] = 8'($urandom % range);
    end
  endtask

  task automatic op_and_check(input logic [1:0] sz, input logic neg);
    logic [PB-1:0] ep;
    logic en, ez, ec;
    int cyc;
    string rq;
    model(vec_a, vec_b, gov, sz[0], neg, ep, en, ez, ec);
    run(sz, neg, cyc);
    rq = sz[0] ? "R3/R4" : (neg ? "R2/R4" : "R1/R4");
    chk(rq, 64'(pred), 64'(ep));
    chk("R5 flags nzcv", {60'd0, flag_n, flag_z, flag_c, flag_v}, {60'd0, en, ez, ec, 1'b0});
    chk("R7 latency", 64'(cyc), 64'(NSEG + 1));
    chk("R8 undef low on legal size", 64'(undef), 64'd0);
    @(negedge clk);
    chk("R7 done one cycle", 64'(done), 64'd0);
    chk("R7 hold", 64'(pred), 64'(ep));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [PB-1:0] keep;
    int cyc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R6 reset pred", 64'(pred), 64'd0);
    chk("R6 reset flags", {60'd0, flag_n, flag_z, flag_c, flag_v, done}, {60'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0});

    // R1 cross-segment: only copy of 0xAA sits in the other segment
    vec_a = '0; vec_b = {PB{8'h55}};
    vec_a[7:0] = 8'hAA; vec_b[135:128] = 8'hAA; gov = '1;
    op_and_check(2'd0, 1'b0);
    chk("R1 no cross-segment match", 64'(pred[0]), 64'd0);

    // sweep modes and sizes with several value ranges and gov patterns
    for (int sz = 0; sz < 2; sz++)
      for (int ng = 0; ng < 2; ng++)
        for (int t = 0; t < 40; t++) begin
          fill((t % 4 == 0) ? 4 : (t % 4 == 1) ? 24 : (t % 4 == 2) ? 64 : 256);
          case (t % 5)
            0: gov = '1;
            1: gov = '0;
            2: gov = PB'(1) << ($urandom % PB);
            default: gov = PB'($urandom);
          endcase
          op_and_check(2'(sz), ng[0]);
        end

    // R6 empty governing predicate
    fill(4); gov = '0;
    op_and_check(2'd0, 1'b1);
    chk("R6 empty pred zero", 64'(pred), 64'd0);

    // R3 odd gov bits only in halfword mode
    fill(2); gov = {(PB/2){2'b10}};
    op_and_check(2'd1, 1'b0);
    chk("R3 odd gov ignored", 64'(pred), 64'd0);

    // R8 illegal sizes keep previous result
    fill(8); gov = '1;
    op_and_check(2'd0, 1'b0);
    keep = pred;
    for (int s = 2; s < 4; s++) begin
      logic fn, fz, fc;
      fn = flag_n; fz = flag_z; fc = flag_c;
      vec_a = ~vec_a; gov = '0;
      run(2'(s), 1'b1, cyc);
      chk("R8 undef", {62'd0, done, undef}, {62'd0, 2'b11});
      chk("R8 latency", 64'(cyc), 64'd1);
      chk("R8 pred unchanged", 64'(pred), 64'(keep));
      chk("R8 flags unchanged", {61'd0, flag_n, flag_z, flag_c}, {61'd0, fn, fz, fc});
      gov = '1; vec_a = ~vec_a;
    end

    // R9 start while busy is ignored
    begin
      logic [PB-1:0] ep;
      logic en, ez, ec;
      fill(16); gov = '1;
      model(vec_a, vec_b, gov, 1'b0, 1'b0, ep, en, ez, ec);
      @(negedge clk);
      size_sel = 2'd0; nomatch = 1'b0; start = 1'b1;
      @(negedge clk);
      vec_a = ~vec_a; gov = '0; nomatch = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cyc = 2;
      while (!done && cyc < 100) begin
        @(negedge clk);
        cyc++;
      end
      chk("R9 busy start ignored pred", 64'(pred), 64'(ep));
      chk("R9 flags", {61'd0, flag_n, flag_z, flag_c}, {61'd0, en, ez, ec});
      chk("R9 latency", 64'(cyc), 64'(NSEG + 1));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule